// File: doc/BRIEF.md
# Receive FIFO Flow-Control Threshold Monitor

This block sits beside the receive FIFO of an Ethernet MAC. It watches two occupancy counters: the number of data bytes held and the number of complete frames held. It decides every clock whether the MAC should request flow control from its link partner. The rest of the MAC programs three 3-bit codes: a byte threshold, a frame threshold and the configured FIFO size. The block compares the counters against the thresholds those codes give. The result is registered into a single flow-control level.

The two conditions are combined with OR. The request stays up for as long as either condition holds, and it drops as soon as both have cleared. A byte threshold set equal to the full FIFO size could never be reached in a useful way, so the trigger point is pulled back by a 64-byte guard in that case. A byte-threshold code above the FIFO-size code is an illegal setting. It is reported on a separate error output, and the byte trigger is held at the guarded FIFO size while the error lasts.

Top module: `rx_fc_monitor`

## Requirements
- R1: While rst_ni is low, fc_active_o and cfg_err_o are 0, and both stay 0 on the first sampled cycle after reset when no condition holds.
- R2: A size code c stands for (c+1)*256 bytes. When the byte-threshold code is below the FIFO-size code, the byte condition holds when fifo_bytes_i >= (byte code + 1)*256.
- R3: The frame condition holds when fifo_frames_i >= (frame code + 1).
- R4: fc_active_o is 1 in the cycle after a clock edge at which the byte condition or the frame condition held. Either condition alone is enough.
- R5: fc_active_o is 0 in the cycle after a clock edge at which neither condition held. It does not stay latched.
- R6: When the byte-threshold code equals the FIFO-size code, the byte trigger is (size code + 1)*256 - 64. With both codes at 7, 1983 bytes do not trigger and 1984 bytes do.
- R7: cfg_err_o is 1 in the cycle after an edge at which the byte-threshold code was greater than the FIFO-size code, and 0 otherwise.
- R8: While the codes are in the error setting of R7, the byte trigger is (FIFO-size code + 1)*256 - 64.
- R9: A change to any code or counter is reflected in the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_bytes_i | input | 12 | Data bytes currently held in the receive FIFO |
| fifo_frames_i | input | 4 | Complete frames currently held in the receive FIFO |
| byte_thr_code_i | input | 3 | Byte-threshold code, (code+1)*256 bytes |
| frame_thr_code_i | input | 3 | Frame-threshold code, (code+1) frames |
| fifo_size_code_i | input | 3 | Configured FIFO size code, (code+1)*256 bytes |
| fc_active_o | output | 1 | Registered flow-control request |
| cfg_err_o | output | 1 | Registered flag: byte-threshold code larger than FIFO-size code |

## Verification
The bench probes the byte trigger one byte below it and exactly at it, in all three cases: an ordinary threshold, a threshold equal to the FIFO size, and the error setting. A design that forgot the 64-byte guard would stay low at 1984 bytes. A design that left the threshold unclamped in the error setting would trigger late or never. The bench also probes the frame count at code+1 and one below, which exposes an off-by-one or a strict compare. It checks that a request drops on the cycle after both conditions clear, which shows up a design that latches or uses AND. Random occupancy values are placed near the thresholds, and every result is compared against a model computed inside the bench.

// File: rtl/fc_thr_pkg.sv
package fc_thr_pkg;
  typedef struct packed {
    logic byte_hit;
    logic frame_hit;
  } fc_hits_t;

  // (code + 1) * unit, as a plain integer
  function automatic int unsigned code_scale(input int unsigned code, input int unsigned unit);
    return (code + 1) * unit;
  endfunction
endpackage

// File: rtl/fc_ge_cmp.sv
module fc_ge_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lim_i,
  output logic         ge_o
);
  assign ge_o = (val_i >= lim_i);
endmodule

// File: rtl/fc_byte_thr.sv
module fc_byte_thr
  import fc_thr_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BYTE_W = 12,
  parameter int UNIT   = 256,
  parameter int GUARD  = 64
) (
  input  logic [CODE_W-1:0] thr_code_i,
  input  logic [CODE_W-1:0] size_code_i,
  output logic [BYTE_W-1:0] eff_thr_o,
  output logic              cfg_err_o
);
  logic [BYTE_W-1:0] size_bytes, thr_bytes, guarded;

  assign size_bytes = BYTE_W'(code_scale(int'(size_code_i), UNIT));
  assign thr_bytes  = BYTE_W'(code_scale(int'(thr_code_i), UNIT));
  assign guarded    = size_bytes - BYTE_W'(GUARD);
  assign cfg_err_o  = (thr_code_i > size_code_i);

  // equal or illegal setting: pull back to size minus guard
  assign eff_thr_o  = (thr_code_i >= size_code_i) ? guarded : thr_bytes;

  always_comb begin
    a_r8_thr_bounded: assert (eff_thr_o <= guarded);
  end
endmodule

// File: rtl/rx_fc_monitor.sv
module rx_fc_monitor
  import fc_thr_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BYTE_W = 12,
  parameter int FRM_W  = 4,
  parameter int UNIT   = 256,
  parameter int GUARD  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] fifo_bytes_i,
  input  logic [FRM_W-1:0]  fifo_frames_i,
  input  logic [CODE_W-1:0] byte_thr_code_i,
  input  logic [CODE_W-1:0] frame_thr_code_i,
  input  logic [CODE_W-1:0] fifo_size_code_i,
  output logic              fc_active_o,
  output logic              cfg_err_o
);
  logic [BYTE_W-1:0] eff_byte_thr;
  logic [FRM_W-1:0]  frame_thr;
  logic              cfg_err_d;
  fc_hits_t          hits;

  fc_byte_thr #(
    .CODE_W(CODE_W), .BYTE_W(BYTE_W), .UNIT(UNIT), .GUARD(GUARD)
  ) u_byte_thr (
    .thr_code_i (byte_thr_code_i),
    .size_code_i(fifo_size_code_i),
    .eff_thr_o  (eff_byte_thr),
    .cfg_err_o  (cfg_err_d)
  );

  assign frame_thr = FRM_W'(code_scale(int'(frame_thr_code_i), 1));

  fc_ge_cmp #(.W(BYTE_W)) u_byte_cmp (
    .val_i(fifo_bytes_i), .lim_i(eff_byte_thr), .ge_o(hits.byte_hit)
  );

  fc_ge_cmp #(.W(FRM_W)) u_frame_cmp (
    .val_i(fifo_frames_i), .lim_i(frame_thr), .ge_o(hits.frame_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_active_o <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      fc_active_o <= hits.byte_hit | hits.frame_hit;
      cfg_err_o   <= cfg_err_d;
    end
  end

  a_r2_byte_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_thr_code_i < fifo_size_code_i &&
     int'(fifo_bytes_i) >= (int'(byte_thr_code_i) + 1) * UNIT) |=> fc_active_o);

  a_r3_frame_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fifo_frames_i) >= int'(frame_thr_code_i) + 1) |=> fc_active_o);

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hits.byte_hit && !hits.frame_hit) |=> !fc_active_o);

  a_r6_guarded_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_thr_code_i == fifo_size_code_i &&
     int'(fifo_bytes_i) >= (int'(fifo_size_code_i) + 1) * UNIT - GUARD) |=> fc_active_o);

  a_r7_cfg_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_thr_code_i > fifo_size_code_i) |=> cfg_err_o);
endmodule

// File: tb/rx_fc_monitor_tb.sv
`timescale 1ns/1ps
module rx_fc_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bytes_q = '0;
  logic [3:0]  frames_q = '0;
  logic [2:0]  bcode = 3'd0, fcode = 3'd7, scode = 3'd7;
  logic        fc_o, err_o;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rx_fc_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_bytes_i(bytes_q), .fifo_frames_i(frames_q),
    .byte_thr_code_i(bcode), .frame_thr_code_i(fcode), .fifo_size_code_i(scode),
    .fc_active_o(fc_o), .cfg_err_o(err_o)
  );

  function automatic int exp_thr(int b, int s);
    if (b >= s) return (s + 1) * 256 - 64;
    return (b + 1) * 256;
  endfunction

  function automatic bit exp_fc(int by, int fr, int b, int f, int s);
    return (by >= exp_thr(b, s)) || (fr >= f + 1);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(string req, int by, int fr, int b, int f, int s);
    bytes_q = 12'(by); frames_q = 4'(fr);
    bcode = 3'(b); fcode = 3'(f); scode = 3'(s);
    @(posedge clk); #1;
    chk(req, fc_o, exp_fc(by, fr, b, f, s));
    chk({req, "_err"}, err_o, b > s);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    bytes_q = 12'd4000; frames_q = 4'd15;
    #12;
    chk("R1", fc_o, 1'b0);
    chk("R1", err_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 0, 0, 7, 7);
    // R2 ordinary threshold 768
    step("R2", 767, 0, 2, 7, 5);
    step("R2", 768, 0, 2, 7, 5);
    // R5 release next cycle
    step("R5", 100, 0, 2, 7, 5);
    // R3 frame threshold 4
    step("R3", 0, 3, 7, 3, 7);
    step("R3", 0, 4, 7, 3, 7);
    // R4 both and either
    step("R4", 2000, 8, 7, 3, 7);
    step("R4", 1984, 0, 7, 3, 7);
    step("R5", 1983, 3, 7, 3, 7);
    // R6 full-size guard
    step("R6", 1983, 0, 7, 7, 7);
    step("R6", 1984, 0, 7, 7, 7);
    step("R6", 447, 0, 1, 7, 1);
    step("R6", 448, 0, 1, 7, 1);
    // R7/R8 illegal setting: size 768 -> 704
    step("R7", 703, 0, 6, 7, 2);
    step("R8", 704, 0, 6, 7, 2);
    step("R8", 1500, 0, 6, 7, 2);
    step("R7", 0, 0, 2, 7, 6);
    // R9 code change alone flips output next edge
    step("R9", 800, 0, 3, 7, 7);
    step("R9", 800, 0, 2, 7, 7);
    for (int i = 0; i < 400; i++) begin
      int b = int'($urandom_range(7, 0));
      int s = int'($urandom_range(7, 0));
      int f = int'($urandom_range(7, 0));
      int t = exp_thr(b, s);
      int by = t + int'($urandom_range(4, 0)) - 2;
      if ($urandom_range(3, 0) == 0) by = int'($urandom_range(4095, 0));
      step("R4", by, int'($urandom_range(15, 0)), b, f, s);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule